// File: doc/BRIEF.md
# Scanline Period Clock-Gating Dejitterer

This block sits between a free-running master video clock and a video processor built only from static logic. It watches the processor's raw composite sync, which is active low, and counts the master cycles between leading (falling) edges. A line one dot short (1360 instead of 1364 cycles) makes the block drop its clock enable for four master cycles. The processor then stalls for exactly the missing time, so its following sync edges fall back onto the 1364-cycle grid. The enable is meant to drive a glitch-free clock gate cell, latch or flop based, placed in front of the processor's clock tree, and optionally the CPU's.

The block also regenerates a clean composite sync from its own line counter, which wraps every 1364 cycles. The pulse width of that sync is taken from the raw pulse of the last properly timed line. The counter is pulled into phase only by edges judged normal, or by the edge that ends a line stretched by a correction. Long lines of 1368 cycles cannot be shortened, so they pass through without gating. Half-line equalizing or serration pulses neither trigger gating nor move the regenerated sync.

Control is a four-state machine. **ARM** counts consecutive normal edges after reset. **WAIT** is the armed idle state. **HOLD** keeps the enable low for one dot. **CATCH** expects the edge that closes the stretched line. Its transitions are: *armed* (ARM to WAIT on the second consecutive normal edge), *short_seen* (WAIT to HOLD on a short edge), *dot_done* (HOLD to CATCH after four cycles) and *caught* (CATCH to WAIT on the next edge of any kind).

Top module: `line_dejitter`

## Requirements
- R1: While reset is asserted, `gate_en` is 1 and `sync_out` is 1 (idle, no pulse).
- R2: Once armed, a raw falling edge 1360 cycles after the previous one drops `gate_en` for exactly 4 consecutive master cycles, starting in the cycle after the edge is detected.
- R3: Lines of 1364 cycles never cause `gate_en` to go low.
- R4: A 1368-cycle line that does not follow a correction is a long line and is not gated.
- R5: After reset, no gating happens until two consecutive 1364-cycle lines have been measured; a short line seen earlier passes uncorrected.
- R6: Across a corrected short line, the falling edges of `sync_out` stay exactly 1364 cycles apart.
- R7: After a correction, the processor's next raw edge arrives 1368 cycles after the short edge (1360 + 1368 = 2 × 1364). That edge counts as corrected: it realigns the regenerated sync and is not gated.
- R8: Half-line pulses (682-cycle spacing) cause no gating and no realignment; `sync_out` keeps its 1364-cycle period through them.
- R9: The `sync_out` low width equals the raw low width measured on a line opened by a normal or corrected edge. It takes effect from the next regenerated period.
- R10: Short lines are detected one by one: in a pattern where every third line is short, each short line gets its own 4-cycle gate.
- R11: `sync_out` is active low, with a default width of 100 cycles until a width has been measured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running master video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Raw composite sync from the video processor, active low |
| gate_en | output | 1 | Clock enable for the processor's clock gate; low while a cycle is suppressed |
| sync_out | output | 1 | Regenerated composite sync with a constant 1364-cycle period, active low |

## Verification
The bench models the processor as a line generator that advances only on cycles where `gate_en` is high, so any gating feeds back into the raw sync timing just as it would in a real system. A steady run of 1364-cycle lines separates correct idling from spurious gating. A single 1360-cycle line shows the 4-cycle gate, the 1368-cycle stretched line that follows it, and the unbroken output period. A lone 1368-cycle line separates an uncorrectable long line from a corrected one. A burst of half-line pulses, a short line right after reset, a change of pulse width, and a repeating short-line pattern cover equalizing pulses, arming, width copying and line-by-line detection.

// File: rtl/dj_pkg.sv
package dj_pkg;

    // Classification of a raw leading sync edge
    typedef enum logic [2:0] {
        EC_NONE,    // no edge this cycle
        EC_NORMAL,  // full-length line ended
        EC_SHORT,   // line one dot short
        EC_LONG,    // line one dot long, uncorrectable
        EC_FIXED,   // stretched line that closes a correction
        EC_OTHER    // any other spacing (half-line pulses, start-up)
    } edge_cls_t;

    // Gate controller states
    typedef enum logic [1:0] {
        GS_ARM,     // counting normal lines after reset
        GS_WAIT,    // armed, idle
        GS_HOLD,    // suppressing master cycles
        GS_CATCH    // expecting the edge that ends the stretched line
    } gate_st_t;

endpackage

// File: rtl/dj_edge_sync.sv
module dj_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic fall,
    output logic rise
);
    // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous level
    logic [STAGES:0] sh;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh[i] <= 1'b1;
                else        sh[i] <= d_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh[i] <= 1'b1;
                else        sh[i] <= sh[i-1];
            end
        end
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];
    assign rise = ~sh[STAGES] & sh[STAGES-1];

endmodule

// File: rtl/dj_line_meter.sv
module dj_line_meter
    import dj_pkg::*;
#(
    parameter int CW        = 12,
    parameter int LINE_CYC  = 1364,
    parameter int SHORT_CYC = 1360,
    parameter int LONG_CYC  = 1368,
    parameter int PW_INIT   = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic          rise,
    input  logic          catch_i,
    output edge_cls_t     cls,
    output logic [CW-1:0] pw_meas
);
    // Counter reads N-1 when an edge arrives N cycles after the last one
    localparam logic [CW-1:0] K_SHORT = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] K_NORM  = CW'(LINE_CYC - 1);
    localparam logic [CW-1:0] K_LONG  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] K_MAX   = '1;

    logic [CW-1:0] cnt;
    logic          open_ok;

    always_comb begin
        cls = EC_NONE;
        if (fall) begin
            if (cnt == K_SHORT)      cls = EC_SHORT;
            else if (cnt == K_NORM)  cls = EC_NORMAL;
            else if (cnt == K_LONG)  cls = catch_i ? EC_FIXED : EC_LONG;
            else                     cls = EC_OTHER;
        end
    end

    // Line length counter, saturating so a lost sync cannot wrap into a match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= K_MAX;
        else if (fall)        cnt <= '0;
        else if (cnt != K_MAX) cnt <= cnt + 1'b1;
    end

    // Pulse width capture, only on lines opened by a trusted edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_ok <= 1'b0;
            pw_meas <= CW'(PW_INIT);
        end else if (fall) begin
            open_ok <= (cls == EC_NORMAL) || (cls == EC_FIXED);
        end else if (rise) begin
            if (open_ok) pw_meas <= cnt + 1'b1;
            open_ok <= 1'b0;
        end
    end

endmodule

// File: rtl/dj_gate_fsm.sv
module dj_gate_fsm
    import dj_pkg::*;
#(
    parameter int DOT_CYC   = 4,
    parameter int ARM_LINES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  edge_cls_t cls,
    output logic      gate_en,
    output logic      catch_o,
    output logic      armed_o
);
    localparam int GW = $clog2(DOT_CYC + 1);
    localparam int AW = $clog2(ARM_LINES + 1);
    localparam logic [GW-1:0] G_LAST = GW'(DOT_CYC - 1);
    localparam logic [AW-1:0] A_LAST = AW'(ARM_LINES - 1);

    gate_st_t      state_q, state_d;
    logic [GW-1:0] gcnt;
    logic [AW-1:0] acnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_ARM;
        else        state_q <= state_d;
    end

    // Transitions: armed, short_seen, dot_done, caught
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_ARM:   if (cls == EC_NORMAL && acnt == A_LAST) state_d = GS_WAIT;
            GS_WAIT:  if (cls == EC_SHORT)                    state_d = GS_HOLD;
            GS_HOLD:  if (gcnt == G_LAST)                     state_d = GS_CATCH;
            GS_CATCH: if (cls != EC_NONE)                     state_d = GS_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        gate_en = 1'b1;
        catch_o = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            GS_ARM:   ;
            GS_WAIT:  armed_o = 1'b1;
            GS_HOLD:  gate_en = 1'b0;
            GS_CATCH: catch_o = 1'b1;
        endcase
    end

    // Dot counter for the suppressed window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gcnt <= '0;
        else if (state_q == GS_HOLD) gcnt <= gcnt + 1'b1;
        else                       gcnt <= '0;
    end

    // Consecutive normal line counter for arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt <= '0;
        end else if (state_q == GS_ARM) begin
            if (cls == EC_NORMAL)   acnt <= (acnt == A_LAST) ? acnt : acnt + 1'b1;
            else if (cls != EC_NONE) acnt <= '0;
        end
    end

endmodule

// File: rtl/dj_sync_regen.sv
module dj_sync_regen
    import dj_pkg::*;
#(
    parameter int CW       = 12,
    parameter int LINE_CYC = 1364,
    parameter int PW_INIT  = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  edge_cls_t     cls,
    input  logic [CW-1:0] pw_meas,
    output logic          sync_out
);
    localparam logic [CW-1:0] K_LAST = CW'(LINE_CYC - 1);

    logic [CW-1:0] rc;
    logic [CW-1:0] pw_q;
    logic          align;
    logic          wrap;

    assign align = (cls == EC_NORMAL) || (cls == EC_FIXED);
    assign wrap  = (rc == K_LAST);

    // Width is reloaded only at a period boundary, so it never cuts a pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc   <= K_LAST;
            pw_q <= CW'(PW_INIT);
        end else if (align || wrap) begin
            rc   <= '0;
            pw_q <= pw_meas;
        end else begin
            rc   <= rc + 1'b1;
        end
    end

    assign sync_out = !(rc < pw_q);

endmodule

// File: rtl/line_dejitter.sv
module line_dejitter
    import dj_pkg::*;
#(
    parameter int LINE_CYC    = 1364,
    parameter int DOT_CYC     = 4,
    parameter int ARM_LINES   = 2,
    parameter int PW_INIT     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic gate_en,
    output logic sync_out
);
    localparam int SHORT_CYC = LINE_CYC - DOT_CYC;
    localparam int LONG_CYC  = LINE_CYC + DOT_CYC;
    localparam int CW        = $clog2(2 * LONG_CYC);

    logic          fall, rise;
    logic          catch_w;
    logic          armed_wait;
    edge_cls_t     edge_cls;
    logic [CW-1:0] pw_meas;

    dj_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (sync_in),
        .fall (fall),
        .rise (rise)
    );

    dj_line_meter #(
        .CW(CW), .LINE_CYC(LINE_CYC), .SHORT_CYC(SHORT_CYC),
        .LONG_CYC(LONG_CYC), .PW_INIT(PW_INIT)
    ) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (fall),
        .rise   (rise),
        .catch_i(catch_w),
        .cls    (edge_cls),
        .pw_meas(pw_meas)
    );

    dj_gate_fsm #(.DOT_CYC(DOT_CYC), .ARM_LINES(ARM_LINES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls    (edge_cls),
        .gate_en(gate_en),
        .catch_o(catch_w),
        .armed_o(armed_wait)
    );

    dj_sync_regen #(.CW(CW), .LINE_CYC(LINE_CYC), .PW_INIT(PW_INIT)) u_regen (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls     (edge_cls),
        .pw_meas (pw_meas),
        .sync_out(sync_out)
    );

endmodule

// File: rtl/line_dejitter_chk.sv
module line_dejitter_chk
    import dj_pkg::*;
#(
    parameter int LINE_CYC = 1364,
    parameter int DOT_CYC  = 4
) (
    input logic      clk,
    input logic      rst_n,
    input logic      gate_en,
    input logic      sync_out,
    input edge_cls_t cls,
    input logic      armed
);
    int   low_run;
    int   per;
    logic so_q, seen, al_q, fall_now;

    assign fall_now = so_q & ~sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
            per     <= 0;
            so_q    <= 1'b1;
            seen    <= 1'b1;
            al_q    <= 1'b0;
        end else begin
            low_run <= gate_en ? 0 : low_run + 1;
            so_q    <= sync_out;
            al_q    <= (cls == EC_NORMAL) || (cls == EC_FIXED);
            if (fall_now) begin
                per  <= 1;
                seen <= 1'b0;
            end else begin
                per  <= (per < 2 * LINE_CYC) ? per + 1 : per;
                seen <= seen | al_q;
            end
        end
    end

    // R2
    gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> low_run < DOT_CYC);

    // R2
    gate_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> low_run == DOT_CYC);

    // R2
    gate_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_en) |-> $past(cls == EC_SHORT && armed));

    // R4
    long_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls == EC_LONG |=> gate_en);

    // R8
    other_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls == EC_OTHER |=> gate_en);

    // R6
    period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_now |-> (per == LINE_CYC || seen || al_q));

endmodule

bind line_dejitter line_dejitter_chk #(
    .LINE_CYC(LINE_CYC), .DOT_CYC(DOT_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_en (gate_en),
    .sync_out(sync_out),
    .cls     (edge_cls),
    .armed   (armed_wait)
);

// File: tb/tb_line_dejitter.sv
`timescale 1ns/1ps
module tb_line_dejitter;
    logic clk = 1'b0;
    logic rst_n;
    logic sync_in;
    logic gate_en;
    logic sync_out;

    line_dejitter dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .gate_en(gate_en), .sync_out(sync_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0;
    int n_fail = 0;

    // Output monitor state
    bit  so_prev = 1'b1, so_have = 1'b0;
    longint so_last;
    int  n_iv, bad_iv, w_run, last_w;
    int  gl_run, gl_runs, gl_bad, gl_last;
    // Raw sync monitor state
    bit  raw_prev = 1'b1, raw_have = 1'b0;
    longint raw_last;
    int  n_raw;
    int  raw_iv [16];

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        so_have = 1'b0; n_iv = 0; bad_iv = 0;
        gl_runs = 0; gl_bad = 0;
        raw_have = 1'b0; n_raw = 0;
    endtask

    // Outputs sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (so_prev && !sync_out) begin
                if (so_have) begin
                    n_iv++;
                    if (($time - so_last) / 4 != 1364) bad_iv++;
                end
                so_have = 1'b1;
                so_last = $time;
            end
            so_prev = sync_out;
            if (!sync_out) w_run++;
            else if (w_run > 0) begin last_w = w_run; w_run = 0; end
            if (!gate_en) gl_run++;
            else if (gl_run > 0) begin
                gl_runs++; gl_last = gl_run;
                if (gl_run != 4) gl_bad++;
                gl_run = 0;
            end
        end
    end

    // Raw input (driven at negedge) sampled at the rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (raw_prev && !sync_in) begin
                if (raw_have && n_raw < 16) begin
                    raw_iv[n_raw] = int'(($time - raw_last) / 4);
                    n_raw++;
                end
                raw_have = 1'b1;
                raw_last = $time;
            end
            raw_prev = sync_in;
        end
    end

    // Processor model: a line of len enabled cycles, low for pw of them
    task automatic run_line(int len, int pw);
        int i = 0;
        while (i < len) begin
            @(negedge clk);
            if (gate_en) begin
                sync_in = (i < pw) ? 1'b0 : 1'b1;
                i++;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sync_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "gate_en in reset", int'(gate_en), 1);
        chk("R1", "sync_out in reset", int'(sync_out), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "gate_en after reset", int'(gate_en), 1);
    endtask

    task automatic t_arming();
        clear_stats();
        run_line(1364, 100);
        run_line(1360, 100);   // short before armed
        run_line(1364, 100);
        run_line(1364, 100);
        chk("R5", "gates before arming", gl_runs, 0);
    endtask

    task automatic t_short();
        run_line(1364, 100);
        run_line(1364, 100);
        clear_stats();
        run_line(1360, 100);
        run_line(1364, 100);
        run_line(1364, 100);
        run_line(1364, 100);
        chk("R2", "gate runs", gl_runs, 1);
        chk("R2", "gate run length", gl_last, 4);
        chk("R6", "off-period sync_out intervals", bad_iv, 0);
        chk("R6", "intervals seen >= 3", int'(n_iv >= 3), 1);
        chk("R7", "raw short line", raw_iv[0], 1360);
        chk("R7", "raw stretched line", raw_iv[1], 1368);
        chk("R7", "raw line after", raw_iv[2], 1364);
        chk("R11", "default sync_out width", last_w, 100);
    endtask

    task automatic t_long();
        run_line(1364, 100);
        run_line(1364, 100);
        clear_stats();
        run_line(1368, 100);
        run_line(1364, 100);
        run_line(1364, 100);
        chk("R4", "gates on long line", gl_runs, 0);
        chk("R4", "off-period intervals <= 1", int'(bad_iv <= 1), 1);
    endtask

    task automatic t_halfline();
        run_line(1364, 100);
        run_line(1364, 100);
        clear_stats();
        for (int k = 0; k < 6; k++) run_line(682, 100);
        run_line(1364, 100);
        run_line(1364, 100);
        run_line(1364, 100);
        chk("R8", "gates on half lines", gl_runs, 0);
        chk("R8", "off-period intervals", bad_iv, 0);
    endtask

    task automatic t_width();
        clear_stats();
        run_line(1364, 96);
        run_line(1364, 96);
        run_line(1364, 96);
        chk("R9", "copied width", last_w, 96);
        run_line(1364, 100);
        run_line(1364, 100);
        chk("R9", "restored width", last_w, 100);
        chk("R3", "gates on normal lines", gl_runs, 0);
        chk("R3", "off-period intervals", bad_iv, 0);
    endtask

    task automatic t_alternate();
        clear_stats();
        for (int k = 0; k < 4; k++) begin
            run_line(1360, 100);
            run_line(1364, 100);
            run_line(1364, 100);
        end
        chk("R10", "gates for 4 short lines", gl_runs, 4);
        chk("R10", "bad gate lengths", gl_bad, 0);
        chk("R10", "off-period intervals", bad_iv, 0);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_arming();
        t_short();
        t_long();
        t_halfline();
        t_width();
        t_alternate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL all watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule